// File: doc/BRIEF.md
# LCD Panel Data Output Formatter

This block sits between the pixel processing stages of an LCD controller and the panel data pins. It takes a stream of already processed pixel values over a valid/ready handshake and packs them into words for an upper and a lower panel data register. The timing generator fires one request strobe for each pixel-clock toggle. On each strobe the block presents the next complete output word.

Four packing formats are supported. The first is monochrome with 4 pins, one bit per pixel. The second is monochrome with 8 pins. The third is passive color, where the red, green and blue bits run continuously across 8 pins, so a pixel may straddle two words. The fourth is direct 16-bit, where the upper and lower registers together carry one pixel per clock. In dual-panel wiring the stream is split by a top/bottom tag. Top-half pixels fill the upper register, bottom-half pixels fill the lower register, and a word goes out only when both halves are complete.

A request that finds no complete word leaves the pins unchanged and sets a sticky underflow flag. The configuration inputs are expected to change only while no pixels are buffered.

Top module: `lcd_pix_fmt`

## Requirements
- R1: After reset, upper_o, lower_o and underflow_o are zero and pix_ready_o is high.
- R2: In mode 0 (mono, 4 pins), each request outputs 4 pixels taken from bit 0 of pix_data_i. The earliest pixel lands in upper_o[3] and the latest in upper_o[0]. upper_o[7:4] is zero, and pix_data_i[15:1] has no effect.
- R3: In mode 1 (mono, 8 pins), each request outputs 8 one-bit pixels with the earliest in upper_o[7].
- R4: In mode 2 (passive color), each pixel contributes pix_data_i[2:0], with bit 2 (red) sent first. The bits are packed MSB-first into 8-bit words with no gaps, so a pixel's leftover bits continue at the top of the next word.
- R5: With dual_i high in modes 0 to 2, pixels tagged pix_bot_i=1 are packed into lower_o in the same format as upper_o. A word is issued only when both halves hold a complete word.
- R6: With dual_i low in modes 0 to 2, pix_bot_i has no effect and lower_o is zero after every issued word.
- R7: In mode 3 (direct 16-bit), each request outputs one pixel, with upper_o = pix_data_i[15:8] and lower_o = pix_data_i[7:0]. dual_i and pix_bot_i have no effect.
- R8: A request that finds no complete word leaves upper_o and lower_o unchanged and sets underflow_o. underflow_o then stays set until reset.
- R9: pix_ready_o is low whenever the lane chosen for the offered pixel cannot take another pixel. With the default 32-bit lane, this happens in mode 3 after two pixels are buffered and none has been output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Packing format: 0 mono4, 1 mono8, 2 color, 3 direct 16-bit |
| dual_i | input | 1 | Dual-panel wiring |
| pix_valid_i | input | 1 | Pixel offered |
| pix_ready_o | output | 1 | Pixel accepted when high with pix_valid_i |
| pix_data_i | input | 16 | Pixel value, right aligned |
| pix_bot_i | input | 1 | Pixel belongs to the bottom half (dual only) |
| pix_req_i | input | 1 | Pixel-clock request from the timing generator |
| upper_o | output | 8 | Upper panel data register |
| lower_o | output | 8 | Lower panel data register |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
A reference model in the bench holds one bit queue for each half and predicts every word from the pixels it has accepted.

- The mono patterns put noise in the unused high data bits. This exposes wrong bit selection and wrong nibble placement.
- The color pattern is eight pixels spanning three words. It shows whether leftover component bits carry across word edges.
- Alternating top/bottom tags in single mode separate routing that honours the tag from routing that ignores it.
- A direct-mode run with dual wiring set, filled to capacity, tests both the byte split and the backpressure.
- A final dual run with only the top half filled must hold the pins and latch the underflow flag, which must stay set through later good words.

// File: rtl/lcd_fmt_pkg.sv
package lcd_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_MONO4    = 2'd0,
    FMT_MONO8    = 2'd1,
    FMT_COLOR    = 2'd2,
    FMT_DIRECT16 = 2'd3
  } fmt_mode_e;

  localparam int unsigned COLOR_BITS = 3;

  function automatic int unsigned fmt_bpp(fmt_mode_e m, int unsigned pix_w);
    case (m)
      FMT_COLOR:    return COLOR_BITS;
      FMT_DIRECT16: return pix_w;
      default:      return 1;
    endcase
  endfunction

  function automatic int unsigned fmt_wlen(fmt_mode_e m, int unsigned out_w);
    case (m)
      FMT_MONO4:    return out_w / 2;
      FMT_DIRECT16: return 2 * out_w;
      default:      return out_w;
    endcase
  endfunction
endpackage

// File: rtl/lcd_fmt_lane.sv
// MSB-first bit accumulator: pop shifts out the head word, push appends below
module lcd_fmt_lane #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned IN_W   = 16,
  parameter int unsigned HEAD_W = 16,
  parameter int unsigned CNT_W  = $clog2(ACC_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [IN_W-1:0]   pdata_i,
  input  logic [CNT_W-1:0]  bpp_i,
  input  logic              pop_i,
  input  logic [CNT_W-1:0]  wlen_i,
  output logic [HEAD_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              room_o
);
  logic [ACC_W-1:0] acc_q, acc_d, acc_pop, mask, ext;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_pop, shamt;

  always_comb begin
    acc_pop = pop_i ? (acc_q << wlen_i) : acc_q;
    cnt_pop = pop_i ? (cnt_q - wlen_i) : cnt_q;
    mask    = (ACC_W'(1) << bpp_i) - ACC_W'(1);
    ext     = ACC_W'(pdata_i) & mask;
    shamt   = CNT_W'(ACC_W) - cnt_pop - bpp_i;
    acc_d   = push_i ? (acc_pop | (ext << shamt)) : acc_pop;
    cnt_d   = push_i ? (cnt_pop + bpp_i) : cnt_pop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // room judged on the pre-pop count: a full lane accepts again one cycle after a pop
  assign room_o = ({1'b0, cnt_q} + {1'b0, bpp_i}) <= (CNT_W + 1)'(ACC_W);
  assign head_o = acc_q[ACC_W-1 -: HEAD_W];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/lcd_fmt_out.sv
module lcd_fmt_out #(
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             pop_i,
  input  logic [OUT_W-1:0] nxt_up_i,
  input  logic [OUT_W-1:0] nxt_lo_i,
  output logic [OUT_W-1:0] upper_o,
  output logic [OUT_W-1:0] lower_o,
  output logic             underflow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_o     <= '0;
      lower_o     <= '0;
      underflow_o <= 1'b0;
    end else if (pop_i) begin
      upper_o <= nxt_up_i;
      lower_o <= nxt_lo_i;
    end else if (req_i) begin
      underflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_pix_fmt.sv
module lcd_pix_fmt
  import lcd_fmt_pkg::*;
#(
  parameter int unsigned OUT_W = 8,
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             dual_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  input  logic [15:0]      pix_data_i,
  input  logic             pix_bot_i,
  input  logic             pix_req_i,
  output logic [OUT_W-1:0] upper_o,
  output logic [OUT_W-1:0] lower_o,
  output logic             underflow_o
);
  localparam int unsigned PIX_W = 2 * OUT_W;
  localparam int unsigned HALF  = OUT_W / 2;
  localparam int unsigned CNT_W = $clog2(ACC_W + 1);

  fmt_mode_e        mode;
  logic [CNT_W-1:0] bpp, wlen;
  logic             dual_eff, sel, accept, word_ok, pop_w;
  logic [1:0]       room, full, lane_push, lane_pop;
  logic [CNT_W-1:0] cnt [2];
  logic [PIX_W-1:0] head0;
  logic [OUT_W-1:0] head1;
  logic [OUT_W-1:0] nxt_up, nxt_lo;

  assign mode     = fmt_mode_e'(mode_i);
  assign bpp      = CNT_W'(fmt_bpp(mode, PIX_W));
  assign wlen     = CNT_W'(fmt_wlen(mode, OUT_W));
  assign dual_eff = dual_i && (mode != FMT_DIRECT16);
  assign sel      = dual_eff && pix_bot_i;
  assign pix_ready_o = room[sel];
  assign accept   = pix_valid_i && pix_ready_o;
  assign word_ok  = full[0] && (!dual_eff || full[1]);
  assign pop_w    = pix_req_i && word_ok;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_push[g] = accept && (sel == (g != 0));
    assign lane_pop[g]  = pop_w && ((g == 0) || dual_eff);
    assign full[g]      = cnt[g] >= wlen;
    if (g == 0) begin : g_top
      lcd_fmt_lane #(.ACC_W(ACC_W), .IN_W(16), .HEAD_W(PIX_W), .CNT_W(CNT_W)) u_lane (
        .clk_i, .rst_ni,
        .push_i(lane_push[g]), .pdata_i(pix_data_i), .bpp_i(bpp),
        .pop_i(lane_pop[g]), .wlen_i(wlen),
        .head_o(head0), .cnt_o(cnt[g]), .room_o(room[g])
      );
    end else begin : g_bot
      lcd_fmt_lane #(.ACC_W(ACC_W), .IN_W(16), .HEAD_W(OUT_W), .CNT_W(CNT_W)) u_lane (
        .clk_i, .rst_ni,
        .push_i(lane_push[g]), .pdata_i(pix_data_i), .bpp_i(bpp),
        .pop_i(lane_pop[g]), .wlen_i(wlen),
        .head_o(head1), .cnt_o(cnt[g]), .room_o(room[g])
      );
    end
  end

  always_comb begin
    nxt_up = head0[PIX_W-1 -: OUT_W];
    nxt_lo = '0;
    case (mode)
      FMT_MONO4: begin
        nxt_up = {{(OUT_W - HALF){1'b0}}, head0[PIX_W-1 -: HALF]};
        if (dual_eff) nxt_lo = {{(OUT_W - HALF){1'b0}}, head1[OUT_W-1 -: HALF]};
      end
      FMT_DIRECT16: nxt_lo = head0[OUT_W-1:0];
      default: if (dual_eff) nxt_lo = head1;
    endcase
  end

  lcd_fmt_out #(.OUT_W(OUT_W)) u_out (
    .clk_i, .rst_ni,
    .req_i(pix_req_i), .pop_i(pop_w),
    .nxt_up_i(nxt_up), .nxt_lo_i(nxt_lo),
    .upper_o, .lower_o, .underflow_o
  );
endmodule

// File: rtl/lcd_pix_fmt_chk.sv
module lcd_pix_fmt_chk #(
  parameter int unsigned OUT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             dual_i,
  input logic             pix_req_i,
  input logic             pop_w,
  input logic [OUT_W-1:0] upper_o,
  input logic [OUT_W-1:0] lower_o,
  input logic             underflow_o
);
  p_hold_on_starve_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_i && !pop_w |=> $stable(upper_o) && $stable(lower_o) && underflow_o);

  p_sticky_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  p_flag_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(pix_req_i));

  p_mono4_high_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_w && (mode_i == 2'd0) |=> upper_o[OUT_W-1:OUT_W/2] == '0);

  p_single_lower_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_w && !dual_i && (mode_i != 2'd3) |=> lower_o == '0);
endmodule

bind lcd_pix_fmt lcd_pix_fmt_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .dual_i(dual_i),
  .pix_req_i(pix_req_i), .pop_w(pop_w),
  .upper_o(upper_o), .lower_o(lower_o), .underflow_o(underflow_o)
);

// File: tb/lcd_pix_fmt_bench.sv
`timescale 1ns/1ps
module lcd_pix_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dual = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [15:0] pix_data = '0;
  logic        pix_bot = 1'b0;
  logic        pix_req = 1'b0;
  logic [7:0]  upper, lower;
  logic        uflow;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lcd_pix_fmt u_lcd_pix_fmt (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dual_i(dual),
    .pix_valid_i(pix_valid), .pix_ready_o(pix_ready), .pix_data_i(pix_data),
    .pix_bot_i(pix_bot), .pix_req_i(pix_req),
    .upper_o(upper), .lower_o(lower), .underflow_o(uflow)
  );

  typedef struct {
    string      tag;
    logic [7:0] up;
    logic [7:0] lo;
    logic       uf;
  } exp_t;

  exp_t exp_q[$];
  bit   tq[$];
  bit   bq[$];
  logic uf_m = 1'b0;
  logic [7:0] last_up = '0, last_lo = '0;
  logic mon_fire = 1'b0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit dual_eff();
    return dual && (mode != 2'd3);
  endfunction

  function automatic int m_bpp();
    case (mode)
      2'd2: return 3;
      2'd3: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic int m_wlen();
    case (mode)
      2'd0: return 4;
      2'd3: return 16;
      default: return 8;
    endcase
  endfunction

  task automatic send_pix(logic [15:0] d, logic bot);
    pix_valid = 1'b1; pix_data = d; pix_bot = bot;
    #1;
    while (!pix_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    for (int i = m_bpp() - 1; i >= 0; i--) begin
      if (dual_eff() && bot) bq.push_back(d[i]);
      else tq.push_back(d[i]);
    end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic do_req(string tag);
    exp_t e;
    logic [15:0] w0, w1;
    int wl;
    bit ok;
    wl = m_wlen();
    ok = (tq.size() >= wl) && (!dual_eff() || bq.size() >= wl);
    if (ok) begin
      w0 = '0; w1 = '0;
      for (int i = 0; i < wl; i++) w0 = {w0[14:0], tq.pop_front()};
      if (dual_eff()) for (int i = 0; i < wl; i++) w1 = {w1[14:0], bq.pop_front()};
      if (mode == 2'd3) begin
        last_up = w0[15:8]; last_lo = w0[7:0];
      end else begin
        last_up = w0[7:0];
        last_lo = dual_eff() ? w1[7:0] : 8'h00;
      end
    end else begin
      uf_m = 1'b1;
    end
    e.tag = tag; e.up = last_up; e.lo = last_lo; e.uf = uf_m;
    exp_q.push_back(e);
    pix_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pix_req = 1'b0;
  endtask

  // monitor: compares the registered outputs one edge after each request
  always @(posedge clk) mon_fire <= pix_req;
  always @(negedge clk) begin
    if (mon_fire) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=%h expected=none", {upper, lower});
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " upper"}, 16'(upper), 16'(e.up));
        check({e.tag, " lower"}, 16'(lower), 16'(e.lo));
        check({e.tag, " underflow"}, 16'(uflow), 16'(e.uf));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk); cyc++;
    end
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] colors [8] = '{3'd5, 3'd3, 3'd6, 3'd1, 3'd7, 3'd0, 3'd2, 3'd4};
    logic mono_a [8] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    repeat (3) @(negedge clk);
    check("R1 reset upper", 16'(upper), 16'h0);
    check("R1 reset lower", 16'(lower), 16'h0);
    check("R1 reset underflow", 16'(uflow), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 16'(pix_ready), 16'h1);

    // R2: mono 4 pins, noise on high data bits
    mode = 2'd0; dual = 1'b0;
    for (int i = 0; i < 8; i++) send_pix({15'h55E0 ^ 15'(i * 3), mono_a[i]}, 1'b0);
    do_req("R2 mono4 word0");
    do_req("R2 mono4 word1");

    // R3 and R6: mono 8 pins, bottom tag toggled in single mode
    mode = 2'd1;
    for (int i = 0; i < 8; i++) send_pix({15'h7FFF, mono_a[7 - i]}, 1'(i % 2));
    do_req("R3 R6 mono8 single");

    // R4: color bits carried across word edges
    mode = 2'd2;
    for (int i = 0; i < 8; i++) send_pix({13'h1ABC, colors[i]}, 1'b0);
    do_req("R4 color word0");
    do_req("R4 color word1");
    do_req("R4 color word2");

    // R5: dual mono4 and dual color
    mode = 2'd0; dual = 1'b1;
    for (int i = 0; i < 4; i++) send_pix(16'(mono_a[i]), 1'b0);
    for (int i = 0; i < 4; i++) send_pix(16'(mono_a[7 - i]), 1'b1);
    do_req("R5 dual mono4");
    mode = 2'd2;
    for (int i = 0; i < 8; i++) send_pix(16'(colors[i]), 1'(i / 4));
    for (int i = 0; i < 8; i++) send_pix(16'(colors[7 - i]), 1'(1 - i / 4));
    do_req("R5 dual color w0");
    do_req("R5 dual color w1");
    do_req("R5 dual color w2");

    // R7 and R9: direct 16-bit with dual set, filled to capacity
    mode = 2'd3; dual = 1'b1;
    send_pix(16'hA55A, 1'b1);
    #1; check("R9 ready with one pixel buffered", 16'(pix_ready), 16'h1);
    send_pix(16'h3C96, 1'b0);
    pix_valid = 1'b1; pix_data = 16'h1234; #1;
    check("R9 ready low when lane full", 16'(pix_ready), 16'h0);
    pix_valid = 1'b0;
    do_req("R7 direct pixel0");
    do_req("R7 direct pixel1");

    // R8: dual with bottom half missing
    mode = 2'd1; dual = 1'b1;
    for (int i = 0; i < 8; i++) send_pix(16'(mono_a[i]), 1'b0);
    do_req("R8 starved bottom holds");
    for (int i = 0; i < 8; i++) send_pix(16'(~mono_a[i]), 1'b1);
    do_req("R8 flag stays after good word");
    do_req("R8 empty lanes hold");

    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", 16'(exp_q.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule